// File: doc/BRIEF.md
# Three-Wire Serial Word Memory (Device Side)

This block is the device end of a three-wire synchronous serial memory link. A host raises chip select, clocks instruction bits in on the data input line and reads results back on a single data output line. The block decodes the instruction and serves a 64-word by 16-bit storage array held in flip-flops. It supports word read, word write, word erase, whole-array erase and write, and a pair of instructions that arm or disarm programming.

All four serial pins are sampled on the system clock. The serial clock edges are detected inside the block. A programming operation is self-timed. It is committed when chip select drops after a complete instruction. A system-clock counter then holds the block busy for `PROG_CYCLES` cycles. While chip select is high, the output line reports whether the programming operation has finished. While chip select is low, the output is not driven; this is shown by `doOe` being low.

Top module: `mw_eeprom`

## Requirements
- R1: With chip select high and the block idle and ready, the first 1 sampled on a serial clock rise is a start bit. The next 8 rises shift in, MSB first, a 2-bit opcode and then a 6-bit word address. Opcode encodings: 10 is word read, 01 is word write, 11 is word erase. Opcode 00 is decoded by address bits [5:4]: 11 arms programming, 00 disarms programming, 10 erases all words, 01 writes all words.
- R2: On a word read, the rise that carries the last address bit drives a 0 dummy bit on the output. Each following rise presents the next bit of the addressed word, bit 15 first.
- R3: While a read is shifting out, the output bit changes only in the system cycle after a detected serial clock rise.
- R4: After reset, programming is disarmed. Word write, word erase, all-erase and all-write then leave the array unchanged.
- R5: After the arm instruction, programming stays allowed until the disarm instruction or a reset. After a disarm, writes are ignored again.
- R6: A word erase sets all 16 bits of the addressed word to 1.
- R7: A word write takes 16 data bits, MSB first, after the address and stores them at the address.
- R8: All-erase sets every word to 0xFFFF. All-write stores its 16 data bits in every word.
- R9: A programming operation is launched only when chip select falls after the instruction is complete. If chip select drops before the last data bit, nothing is programmed.
- R10: After a launch, the block is busy for `PROG_CYCLES` system cycles. With chip select high and no new instruction accepted, the output is driven and reads 0 while busy and 1 once finished.
- R11: While chip select is low, the output is not driven (`doOe`=0) and the instruction decoder returns to idle. A partly shifted instruction is discarded.
- R12: A start bit that arrives while programming is busy is ignored, so the whole instruction it would begin has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial clock from the host |
| diIn | input | 1 | Serial data into the block |
| doOut | output | 1 | Serial data out, or the ready (1) / busy (0) flag |
| doOe | output | 1 | Output enable for doOut; 0 means high impedance |

## Verification
The bench targets the dummy zero ahead of read data. A design that omits it returns every word shifted by one bit. It writes while disarmed and again after a disarm; a design that ignores the arm flag corrupts words the bench model still holds. It drops chip select halfway through the data bits, which catches a design that commits a partial word. It also sends a complete write while an earlier write is still busy; if that start bit were accepted, the array would differ from the model. The ready flag is sampled both inside and just past the busy window to catch an off-by-a-lot counter.

// File: rtl/mw_pkg.sv
package mw_pkg;
  parameter int ADDR_W = 6;
  parameter int DATA_W = 16;
  parameter int OPC_W  = 2;
  localparam int CMD_W = OPC_W + ADDR_W;
  localparam int WORDS = 1 << ADDR_W;

  localparam logic [OPC_W-1:0] OPC_MISC  = 2'b00;
  localparam logic [OPC_W-1:0] OPC_WRITE = 2'b01;
  localparam logic [OPC_W-1:0] OPC_READ  = 2'b10;
  localparam logic [OPC_W-1:0] OPC_ERASE = 2'b11;

  localparam logic [1:0] SUB_DIS  = 2'b00;
  localparam logic [1:0] SUB_WALL = 2'b01;
  localparam logic [1:0] SUB_EALL = 2'b10;
  localparam logic [1:0] SUB_EN   = 2'b11;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_ARMED, ST_HOLD
  } ctrlState_t;

  typedef struct packed {
    logic              shiftData;
    logic              loadRead;
    logic              shiftOut;
    logic              progStart;
    logic              progAll;
    logic              progErase;
    logic [ADDR_W-1:0] addr;
  } dpStrobe_t;
endpackage

// File: rtl/mw_datapath.sv
module mw_datapath
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 400
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      diIn,
  input  dpStrobe_t ctl,
  output logic      outBit,
  output logic      busy
);
  localparam int BUSY_W = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] dataShift;
  logic [DATA_W:0]   outReg;
  logic [BUSY_W-1:0] busyCnt;
  logic [WORDS-1:0]  wrHit;
  logic [DATA_W-1:0] progValue;

  // one write-enable per word
  for (genvar w = 0; w < WORDS; w++) begin : g_hit
    assign wrHit[w] = ctl.progStart && (ctl.progAll || ctl.addr == ADDR_W'(w));
  end

  assign progValue = ctl.progErase ? {DATA_W{1'b1}} : dataShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (wrHit[i]) mem[i] <= progValue;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataShift <= '0;
      outReg    <= '0;
      busyCnt   <= '0;
    end else begin
      if (ctl.shiftData) dataShift <= {dataShift[DATA_W-2:0], diIn};
      if (ctl.loadRead)      outReg <= {1'b0, mem[ctl.addr]};
      else if (ctl.shiftOut) outReg <= {outReg[DATA_W-1:0], 1'b0};
      if (ctl.progStart)       busyCnt <= BUSY_W'(PROG_CYCLES);
      else if (busyCnt != '0)  busyCnt <= busyCnt - 1'b1;
    end
  end

  assign outBit = outReg[DATA_W];
  assign busy   = (busyCnt != '0);

  p_busy_countdown_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busyCnt != '0 && !ctl.progStart) |=> busyCnt == $past(busyCnt) - 1'b1);

  p_read_dummy_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadRead |=> !outBit);

  p_erase_fills_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.progStart && ctl.progErase && !ctl.progAll) |=> mem[$past(ctl.addr)] == {DATA_W{1'b1}});
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csIn,
  input  logic      skIn,
  input  logic      diIn,
  input  logic      busy,
  input  logic      outBit,
  output dpStrobe_t dpCtl,
  output logic      doOut,
  output logic      doOe
);
  localparam int MAX_BITS = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int CNT_W    = $clog2(MAX_BITS);

  ctrlState_t        state;
  logic              skPrev;
  logic              skRise;
  logic [CNT_W-1:0]  bitCnt;
  logic [CMD_W-1:0]  cmdShift;
  logic [CMD_W-1:0]  fullCmd;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] addrIn;
  logic [1:0]        subOp;
  logic [ADDR_W-1:0] pendAddr;
  logic              pendAll;
  logic              pendErase;
  logic              writeEn;
  logic              statusShow;
  logic              cmdLast;
  logic              dataLast;

  assign skRise   = csIn && skIn && !skPrev;
  assign fullCmd  = {cmdShift[CMD_W-2:0], diIn};
  assign opc      = fullCmd[CMD_W-1 -: OPC_W];
  assign addrIn   = fullCmd[ADDR_W-1:0];
  assign subOp    = addrIn[ADDR_W-1 -: 2];
  assign cmdLast  = (bitCnt == CNT_W'(CMD_W - 1));
  assign dataLast = (bitCnt == CNT_W'(DATA_W - 1));

  always_comb begin
    dpCtl           = '0;
    dpCtl.addr      = (state == ST_CMD) ? addrIn : pendAddr;
    dpCtl.progAll   = pendAll;
    dpCtl.progErase = pendErase;
    dpCtl.shiftData = skRise && state == ST_DATA;
    dpCtl.loadRead  = skRise && state == ST_CMD && cmdLast && opc == OPC_READ;
    dpCtl.shiftOut  = skRise && state == ST_READ;
    dpCtl.progStart = !csIn && state == ST_ARMED && writeEn && !busy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      skPrev     <= 1'b0;
      bitCnt     <= '0;
      cmdShift   <= '0;
      pendAddr   <= '0;
      pendAll    <= 1'b0;
      pendErase  <= 1'b0;
      writeEn    <= 1'b0;
      statusShow <= 1'b0;
    end else begin
      skPrev <= skIn;
      if (!csIn) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        if (dpCtl.progStart) statusShow <= 1'b1;
      end else if (skRise) begin
        case (state)
          ST_IDLE: begin
            if (diIn && !busy) begin
              state      <= ST_CMD;
              bitCnt     <= '0;
              statusShow <= 1'b0;
            end
          end
          ST_CMD: begin
            cmdShift <= fullCmd;
            bitCnt   <= bitCnt + 1'b1;
            if (cmdLast) begin
              bitCnt   <= '0;
              pendAddr <= addrIn;
              case (opc)
                OPC_READ:  state <= ST_READ;
                OPC_WRITE: begin state <= ST_DATA;  pendAll <= 1'b0; pendErase <= 1'b0; end
                OPC_ERASE: begin state <= ST_ARMED; pendAll <= 1'b0; pendErase <= 1'b1; end
                default: begin
                  case (subOp)
                    SUB_EN:   begin writeEn <= 1'b1; state <= ST_HOLD; end
                    SUB_DIS:  begin writeEn <= 1'b0; state <= ST_HOLD; end
                    SUB_EALL: begin state <= ST_ARMED; pendAll <= 1'b1; pendErase <= 1'b1; end
                    default:  begin state <= ST_DATA;  pendAll <= 1'b1; pendErase <= 1'b0; end
                  endcase
                end
              endcase
            end
          end
          ST_DATA: begin
            bitCnt <= bitCnt + 1'b1;
            if (dataLast) state <= ST_ARMED;
          end
          default: ;
        endcase
      end
    end
  end

  assign doOe  = csIn && (state == ST_READ || (state == ST_IDLE && statusShow));
  assign doOut = (state == ST_READ) ? outBit : !busy;

  p_prog_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(writeEn));

  p_prog_on_cs_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!csIn));

  p_dout_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && $past(state == ST_READ) && !$past(skRise)) |-> $stable(doOut));

  p_cs_low_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !csIn |=> state == ST_IDLE);

  p_busy_ignores_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && busy) |=> state != ST_CMD);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  output logic doOut,
  output logic doOe
);
  dpStrobe_t dpCtl;
  logic      busy;
  logic      outBit;

  mw_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .csIn   (csIn),
    .skIn   (skIn),
    .diIn   (diIn),
    .busy   (busy),
    .outBit (outBit),
    .dpCtl  (dpCtl),
    .doOut  (doOut),
    .doOe   (doOe)
  );

  mw_datapath #(.PROG_CYCLES(PROG_CYCLES)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .diIn   (diIn),
    .ctl    (dpCtl),
    .outBit (outBit),
    .busy   (busy)
  );
endmodule

// File: tb/mw_eeprom_tb.sv
`timescale 1ns/1ps
module mw_eeprom_tb;
  localparam int PROG = 400;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic skIn = 1'b0;
  logic diIn = 1'b0;
  logic doOut;
  logic doOe;

  int checks = 0;
  int failures = 0;
  logic [15:0] model [64];
  logic modelWen = 1'b0;
  logic lastDo;
  logic lastOe;

  always #10 clk = ~clk;

  mw_eeprom #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .csIn(csIn), .skIn(skIn), .diIn(diIn),
    .doOut(doOut), .doOe(doOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input int a);
    return model[a];
  endfunction

  task automatic clockBit(input logic b);
    @(negedge clk) diIn = b;
    @(negedge clk) skIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    lastDo = doOut;
    lastOe = doOe;
    skIn = 1'b0;
  endtask

  task automatic csHigh();
    @(negedge clk) csIn = 1'b1;
  endtask

  task automatic csLow();
    @(negedge clk) begin csIn = 1'b0; diIn = 1'b0; end
    repeat (3) @(negedge clk);
  endtask

  task automatic sendCmd(input logic [1:0] opc, input logic [5:0] addr);
    csHigh();
    clockBit(1'b1);
    for (int i = 1; i >= 0; i--) clockBit(opc[i]);
    for (int i = 5; i >= 0; i--) clockBit(addr[i]);
  endtask

  task automatic sendData(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) clockBit(d[i]);
  endtask

  task automatic waitReady();
    repeat (PROG + 10) @(negedge clk);
  endtask

  task automatic doRead(input logic [5:0] addr, input string req);
    logic [15:0] got;
    sendCmd(2'b10, addr);
    chk("R2 dummy bit", {31'd0, lastDo}, 32'd0);
    for (int i = 15; i >= 0; i--) begin
      clockBit(1'b0);
      got[i] = lastDo;
      @(negedge clk);
      if (i == 7) chk("R3 stable between rises", {31'd0, doOut}, {31'd0, lastDo});
    end
    chk(req, {16'd0, got}, {16'd0, expWord(addr)});
    csLow();
  endtask

  task automatic doWrite(input logic [5:0] addr, input logic [15:0] d);
    sendCmd(2'b01, addr);
    sendData(d);
    csLow();
    if (modelWen) model[addr] = d;
    waitReady();
  endtask

  task automatic doErase(input logic [5:0] addr);
    sendCmd(2'b11, addr);
    csLow();
    if (modelWen) model[addr] = 16'hFFFF;
    waitReady();
  endtask

  task automatic setEnable(input logic en);
    sendCmd(2'b00, en ? 6'b110000 : 6'b000000);
    csLow();
    modelWen = en;
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 no drive after reset", {31'd0, doOe}, 32'd0);

    // R1 R2 read of reset contents
    doRead(6'd9, "R1 read after reset");

    // R4 write while disarmed
    doWrite(6'd5, 16'h1234);
    doRead(6'd5, "R4 disarmed write ignored");

    // R7 R1 enable and write
    setEnable(1'b1);
    doWrite(6'd5, 16'hA5C3);
    doRead(6'd5, "R7 write stored");

    // R10 status flag timing, R12 write during busy ignored
    sendCmd(2'b01, 6'd20);
    sendData(16'h0F0F);
    csLow();
    model[20] = 16'h0F0F;
    csHigh();
    repeat (2) @(negedge clk);
    chk("R10 busy drives output", {31'd0, doOe}, 32'd1);
    chk("R10 busy reads 0", {31'd0, doOut}, 32'd0);
    clockBit(1'b1);
    for (int i = 0; i < 24; i++) clockBit(1'b1);
    chk("R12 start ignored, status still shown", {30'd0, lastOe, lastDo}, 32'd2);
    csLow();
    csHigh();
    repeat (PROG + 10) @(negedge clk);
    chk("R10 ready reads 1", {30'd0, doOe, doOut}, 32'd3);
    csLow();
    chk("R11 cs low no drive", {31'd0, doOe}, 32'd0);
    doRead(6'd20, "R12 busy-time write ignored");
    doRead(6'd63, "R12 all-ones write ignored");

    // R6 erase
    doErase(6'd7);
    doRead(6'd7, "R6 erase to ones");

    // R9 abort mid data
    sendCmd(2'b01, 6'd5);
    for (int i = 0; i < 8; i++) clockBit(1'b0);
    csLow();
    waitReady();
    doRead(6'd5, "R9 aborted write");

    // R11 partial instruction discarded
    csHigh();
    clockBit(1'b1);
    clockBit(1'b0);
    clockBit(1'b1);
    csLow();
    doRead(6'd5, "R11 fresh instruction after cs low");

    // R5 disarm
    setEnable(1'b0);
    doWrite(6'd5, 16'h5555);
    doRead(6'd5, "R5 disarmed again");
    setEnable(1'b1);

    // R8 all-erase and all-write
    sendCmd(2'b00, 6'b100000);
    csLow();
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    waitReady();
    doRead(6'd0, "R8 all-erase word 0");
    doRead(6'd42, "R8 all-erase word 42");
    sendCmd(2'b00, 6'b010000);
    sendData(16'h3C96);
    csLow();
    for (int i = 0; i < 64; i++) model[i] = 16'h3C96;
    waitReady();
    doRead(6'd1, "R8 all-write word 1");
    doRead(6'd63, "R8 all-write word 63");

    // random mix, R1 R4 R5 R6 R7
    for (int n = 0; n < 60; n++) begin
      int sel = int'($urandom_range(0, 9));
      logic [5:0] a = 6'($urandom_range(0, 63));
      logic [15:0] d = 16'($urandom);
      if (sel < 4)       doWrite(a, d);
      else if (sel < 5)  doErase(a);
      else if (sel < 6)  setEnable($urandom_range(0, 3) != 0);
      else               doRead(a, "R1 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule